// File: doc/BRIEF.md
# Clock Source Startup and Switch Sequencer

This block chooses which oscillator drives the system clock. There are three sources: a high-speed built-in RC oscillator, a low-speed built-in RC oscillator and an external high-speed clock input. Out of reset the system runs on the high-speed RC clock. When software sets the oscillator enable bit while the mode field selects external-clock operation, the block waits 512 high-speed RC cycles. It then counts 128 cycles of the external clock in that clock's own domain. After that it moves the system clock onto the external source without a glitch and raises a status bit.

A software STOP request gates the system clock off completely. An external wake interrupt restarts it in stages. First 29 low-speed RC cycles are counted, then 512 high-speed RC cycles. The RC clock is then supplied as the system clock. If external mode is still enabled, the block hands over to the external clock on its own after 128 further external cycles. Clearing the enable, or leaving external mode, returns the system clock to RC and discards any partial count.

The control logic runs on the high-speed RC clock, which is assumed free-running. The enable, mode, stop and wake inputs are assumed synchronous to that clock. STOP gates only the output.

Top module: `clk_src_seq`

## Requirements
- R1: While reset is held and after it is released, the system clock follows the high-speed RC clock and `ext_active` reads 0.
- R2: With `osc_mode` = 2'b11, setting `osc_en` starts the sequence. The external clock becomes the system clock no earlier than 512 high-speed RC periods plus 128 external periods after the enable was set.
- R3: While `osc_mode` is not 2'b11, setting `osc_en` has no effect: the system clock stays on the RC source and `ext_active` stays 0.
- R4: Clearing `osc_en` returns the system clock to the RC source. If it is set again, the full 512 + 128 count is needed before the external clock takes over; a partial count is not reused.
- R5: A one-cycle pulse on `stop_req` stops the system clock. No edge appears on `sys_clk` until a wake.
- R6: After a one-cycle pulse on `wake_irq` in STOP, the RC clock reappears on `sys_clk` no earlier than 29 low-speed RC periods plus 512 high-speed RC periods after the pulse.
- R7: After a wake with `osc_en` = 1 and `osc_mode` = 2'b11, the system clock moves to the external source with no further input, no earlier than 128 external periods after the RC clock resumed.
- R8: After a wake with `osc_en` = 0, the system clock stays on the RC source.
- R9: Every rising edge of `sys_clk` coincides with a rising edge of the selected source. The two source gates are never open at the same time.
- R10: `ext_active` is 1 only once the external clock is driving `sys_clk`, and 0 while the RC clock drives it. It is registered in the `sys_clk` domain.
- R11: Each settling counter returns to zero whenever its stage is not active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hrc | input | 1 | High-speed built-in RC clock; also clocks the control logic |
| clk_lrc | input | 1 | Low-speed built-in RC clock |
| clk_ext | input | 1 | External high-speed clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | Software enable for the high-speed oscillation sequence |
| osc_mode | input | 2 | Clock mode field; 2'b11 selects external-clock operation |
| stop_req | input | 1 | One-cycle STOP-mode request |
| wake_irq | input | 1 | One-cycle external wake interrupt |
| sys_clk | output | 1 | Gated, glitch-free system clock |
| ext_active | output | 1 | 1 when the external clock drives `sys_clk` |

## Verification
The bench runs the handover under several patterns:
- An enable in a non-external mode separates a correct mode decode from one that reacts to any set enable.
- A clean enable and an enable that is cleared part-way through its count separate a counter that restarts from one that resumes.
- A STOP/wake round trip with the enable held, and another with it cleared, separates the automatic handover after wake from an unconditional one.

Every `sys_clk` edge is timed against the known phases of the sources, so a glitch, a wrong source or a source change that comes too early is caught at the point where it occurs.

// File: rtl/clk_src_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the clock source sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package clk_src_seq_pkg;
    typedef enum logic [2:0] {
        ST_RC   = 3'd0,   // running on RC clock, idle
        ST_HCNT = 3'd1,   // counting high-speed RC cycles after enable
        ST_XCNT = 3'd2,   // counting external cycles, output on RC
        ST_EXT  = 3'd3,   // output on external clock
        ST_STOP = 3'd4,   // output gated off
        ST_LCNT = 3'd5,   // wake: counting low-speed RC cycles
        ST_WCNT = 3'd6    // wake: counting high-speed RC cycles
    } seq_state_t;

    localparam logic [1:0] MODE_EXT = 2'b11;
endpackage

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a level signal into the domain of clk.
// Assumes: d is a slowly changing level; synchronous active-low reset.
module bit_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;

    // Two-stage capture of d.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/settle_cnt.sv
`timescale 1ns/1ps
// Settling counter: while start is high it counts clock edges up to TARGET
// and then holds done; when start is low it clears to zero.
// Assumes: start is already synchronous to clk.
module settle_cnt #(
    parameter int TARGET = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int W = $clog2(TARGET + 1);
    localparam logic [W-1:0] LIMIT = W'(TARGET);

    logic [W-1:0] cnt_q;

    assign done = (cnt_q == LIMIT);

    // Count while the stage is active; clear when it is left.
    always_ff @(posedge clk) begin
        if (!rst_n || !start) cnt_q <= '0;
        else if (!done)       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cross_counter.sv
`timescale 1ns/1ps
// Settling counter placed in a foreign clock domain. The start level from the
// control domain is synchronized into clk_cnt, and done is synchronized back
// into clk_ctl. When SAME_DOMAIN is set, both synchronizers are left out.
// Assumes: start stays low for longer than the round trip before it is raised again.
module cross_counter #(
    parameter int TARGET      = 128,
    parameter bit SAME_DOMAIN = 1'b0
) (
    input  logic clk_ctl,
    input  logic clk_cnt,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    logic start_c;
    logic done_c;

    generate
        if (SAME_DOMAIN) begin : g_local
            assign start_c = start;
            assign done    = done_c;
        end else begin : g_cross
            bit_sync #(.RST_VAL(1'b0)) u_sync_in (
                .clk(clk_cnt), .rst_n(rst_n), .d(start), .q(start_c));
            bit_sync #(.RST_VAL(1'b0)) u_sync_out (
                .clk(clk_ctl), .rst_n(rst_n), .d(done_c), .q(done));
        end
    endgenerate

    settle_cnt #(.TARGET(TARGET)) u_cnt (
        .clk(clk_cnt), .rst_n(rst_n), .start(start_c), .done(done_c));
endmodule

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
// Sequencer FSM in the high-speed RC domain. It decides which counting stage
// is active, which source the clock switch should select, and when the
// output is gated off.
// Assumes: all control inputs are synchronous to clk; stop_req and wake_irq are pulses.
module seq_ctrl
    import clk_src_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic [1:0] osc_mode,
    input  logic       stop_req,
    input  logic       wake_irq,
    input  logic       hrc_done,
    input  logic       lrc_done,
    input  logic       ext_done,
    output logic       hrc_start,
    output logic       lrc_start,
    output logic       ext_start,
    output logic       sel_ext,
    output logic       gate_off,
    output seq_state_t state
);
    seq_state_t nxt;
    logic       mode_ok;

    assign mode_ok = osc_en && (osc_mode == MODE_EXT);

    // Next-state selection; a STOP request overrides an abort.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RC:   if (stop_req) nxt = ST_STOP;
                     else if (mode_ok) nxt = ST_HCNT;
            ST_HCNT: if (stop_req) nxt = ST_STOP;
                     else if (!mode_ok) nxt = ST_RC;
                     else if (hrc_done) nxt = ST_XCNT;
            ST_XCNT: if (stop_req) nxt = ST_STOP;
                     else if (!mode_ok) nxt = ST_RC;
                     else if (ext_done) nxt = ST_EXT;
            ST_EXT:  if (stop_req) nxt = ST_STOP;
                     else if (!mode_ok) nxt = ST_RC;
            ST_STOP: if (wake_irq) nxt = ST_LCNT;
            ST_LCNT: if (lrc_done) nxt = ST_WCNT;
            ST_WCNT: if (hrc_done) nxt = mode_ok ? ST_XCNT : ST_RC;
            default: nxt = ST_RC;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RC;
        else        state <= nxt;
    end

    assign hrc_start = (state == ST_HCNT) || (state == ST_WCNT);
    assign lrc_start = (state == ST_LCNT);
    assign ext_start = (state == ST_XCNT) || (state == ST_EXT);
    assign sel_ext   = (state == ST_EXT);
    assign gate_off  = (state == ST_STOP) || (state == ST_LCNT) || (state == ST_WCNT);
endmodule

// File: rtl/glitchless_mux.sv
`timescale 1ns/1ps
// Glitch-free two-input clock switch. The gate of each source opens only
// after the other gate is seen closed through a two-flop synchronizer in
// the source's own domain. Each gate changes on its source's falling edge.
// Assumes: both clocks run during reset; source A is selected out of reset.
module glitchless_mux (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic sel_b,
    input  logic off,
    output logic en_a,
    output logic en_b,
    output logic clk_out
);
    logic req_a, req_b, req_a_s, req_b_s;

    assign req_a = !off && !sel_b && !en_b;
    assign req_b = !off &&  sel_b && !en_a;

    bit_sync #(.RST_VAL(1'b1)) u_sync_a (.clk(clk_a), .rst_n(rst_n), .d(req_a), .q(req_a_s));
    bit_sync #(.RST_VAL(1'b0)) u_sync_b (.clk(clk_b), .rst_n(rst_n), .d(req_b), .q(req_b_s));

    // Gate for source A, updated while clk_a is low.
    always_ff @(negedge clk_a) begin
        if (!rst_n) en_a <= 1'b1;
        else        en_a <= req_a_s;
    end

    // Gate for source B, updated while clk_b is low.
    always_ff @(negedge clk_b) begin
        if (!rst_n) en_b <= 1'b0;
        else        en_b <= req_b_s;
    end

    assign clk_out = (clk_a & en_a) | (clk_b & en_b);
endmodule

// File: rtl/clk_src_seq.sv
`timescale 1ns/1ps
// Top of the clock source startup and switch sequencer. It ties the FSM,
// the three settling counters (high-speed RC, low-speed RC, external), the
// glitch-free switch and the status register in the system-clock domain.
// Assumes: clk_hrc is free-running; STOP gates only the output.
module clk_src_seq
    import clk_src_seq_pkg::*;
#(
    parameter int HRC_SETTLE = 512,
    parameter int LRC_SETTLE = 29,
    parameter int EXT_SETTLE = 128
) (
    input  logic       clk_hrc,
    input  logic       clk_lrc,
    input  logic       clk_ext,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic [1:0] osc_mode,
    input  logic       stop_req,
    input  logic       wake_irq,
    output logic       sys_clk,
    output logic       ext_active
);
    seq_state_t state;
    logic hrc_start, lrc_start, ext_start;
    logic hrc_done, lrc_done, ext_done;
    logic sel_ext, gate_off, en_rc, en_ext;
    logic stat_meta_q;

    seq_ctrl u_ctrl (
        .clk(clk_hrc), .rst_n(rst_n), .osc_en(osc_en), .osc_mode(osc_mode),
        .stop_req(stop_req), .wake_irq(wake_irq),
        .hrc_done(hrc_done), .lrc_done(lrc_done), .ext_done(ext_done),
        .hrc_start(hrc_start), .lrc_start(lrc_start), .ext_start(ext_start),
        .sel_ext(sel_ext), .gate_off(gate_off), .state(state));

    cross_counter #(.TARGET(HRC_SETTLE), .SAME_DOMAIN(1'b1)) u_hcnt (
        .clk_ctl(clk_hrc), .clk_cnt(clk_hrc), .rst_n(rst_n),
        .start(hrc_start), .done(hrc_done));

    cross_counter #(.TARGET(LRC_SETTLE), .SAME_DOMAIN(1'b0)) u_lcnt (
        .clk_ctl(clk_hrc), .clk_cnt(clk_lrc), .rst_n(rst_n),
        .start(lrc_start), .done(lrc_done));

    cross_counter #(.TARGET(EXT_SETTLE), .SAME_DOMAIN(1'b0)) u_xcnt (
        .clk_ctl(clk_hrc), .clk_cnt(clk_ext), .rst_n(rst_n),
        .start(ext_start), .done(ext_done));

    glitchless_mux u_mux (
        .clk_a(clk_hrc), .clk_b(clk_ext), .rst_n(rst_n),
        .sel_b(sel_ext), .off(gate_off),
        .en_a(en_rc), .en_b(en_ext), .clk_out(sys_clk));

    // Status: the external gate state, registered in the system-clock domain.
    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            stat_meta_q <= 1'b0;
            ext_active  <= 1'b0;
        end else begin
            stat_meta_q <= en_ext;
            ext_active  <= stat_meta_q;
        end
    end
endmodule

// File: rtl/clk_src_seq_chk.sv
`timescale 1ns/1ps
// Checker for clk_src_seq, bound into every instance. Its properties are
// sampled on the high-speed RC clock.
module clk_src_seq_chk
    import clk_src_seq_pkg::*;
#(
    parameter int HW = 10
) (
    input logic          clk_hrc,
    input logic          rst_n,
    input seq_state_t    state,
    input logic          en_rc,
    input logic          en_ext,
    input logic          sel_ext,
    input logic          ext_done,
    input logic          lrc_done,
    input logic          hrc_start,
    input logic [HW-1:0] hrc_cnt,
    input logic          ext_active
);
    // R9: the two source gates are never open together
    p_one_gate_r9: assert property (@(posedge clk_hrc) disable iff (!rst_n)
        !(en_rc && en_ext));

    // R2: the external source is selected only once its count is done
    p_ext_after_count_r2: assert property (@(posedge clk_hrc) disable iff (!rst_n)
        $rose(sel_ext) |-> ext_done);

    // R6: the high-speed wake count starts only after the low-speed count
    p_wake_order_r6: assert property (@(posedge clk_hrc) disable iff (!rst_n)
        (state == ST_WCNT && $past(state) == ST_LCNT) |-> $past(lrc_done));

    // R5: the RC gate does not reopen while stopped or while counting the low-speed RC clock
    p_no_rc_in_stop_r5: assert property (@(posedge clk_hrc) disable iff (!rst_n)
        $rose(en_rc) |-> !(state inside {ST_STOP, ST_LCNT}));

    // R11: the high-speed counter is cleared once its stage is inactive
    p_cnt_clear_r11: assert property (@(posedge clk_hrc) disable iff (!rst_n)
        !hrc_start |=> (hrc_cnt == '0));

    // R10: the status rises only while the external gate is open
    p_status_r10: assert property (@(posedge clk_hrc) disable iff (!rst_n)
        $rose(ext_active) |-> en_ext);
endmodule

bind clk_src_seq clk_src_seq_chk #(.HW($clog2(HRC_SETTLE + 1))) u_chk (
    .clk_hrc(clk_hrc), .rst_n(rst_n), .state(state),
    .en_rc(en_rc), .en_ext(en_ext), .sel_ext(sel_ext),
    .ext_done(ext_done), .lrc_done(lrc_done),
    .hrc_start(hrc_start), .hrc_cnt(u_hcnt.u_cnt.cnt_q),
    .ext_active(ext_active));

// File: tb/tb_clk_src_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected source changes together with
// time windows, and the monitor classifies each sys_clk edge by its phase
// and pops one item per observed change.
module tb_clk_src_seq;
    localparam int SRC_RC  = 1;
    localparam int SRC_EXT = 2;

    logic clk_hrc, clk_lrc, clk_ext, rst_n;
    logic osc_en, stop_req, wake_irq;
    logic [1:0] osc_mode;
    logic sys_clk, ext_active;

    int n_checks = 0;
    int n_fails  = 0;
    bit done_flag = 0;

    typedef struct {
        int     src;
        longint tmin;
        longint tmax;
        string  req;
    } exp_t;
    exp_t   sb_q[$];
    int     cur_src   = 0;
    longint last_edge = 0;
    int     edge_cnt  = 0;

    clk_src_seq dut (
        .clk_hrc(clk_hrc), .clk_lrc(clk_lrc), .clk_ext(clk_ext), .rst_n(rst_n),
        .osc_en(osc_en), .osc_mode(osc_mode), .stop_req(stop_req),
        .wake_irq(wake_irq), .sys_clk(sys_clk), .ext_active(ext_active));

    // 200 MHz high-speed RC clock: rising edges at 2.5 ns + k*5 ns.
    initial begin clk_hrc = 0; forever #2.5 clk_hrc = ~clk_hrc; end
    // 125 MHz external clock: rising edges at 1.3 ns + k*8 ns.
    initial begin
        clk_ext = 0; #1.3;
        forever begin clk_ext = 1; #4; clk_ext = 0; #4; end
    end
    // 10 MHz low-speed RC clock.
    initial begin clk_lrc = 0; forever #50 clk_lrc = ~clk_lrc; end

    function automatic longint now_ps();
        return longint'($realtime * 1000.0);
    endfunction

    function automatic int classify(longint t);
        if (t % 5000 == 2500) return SRC_RC;
        if (t % 8000 == 1300) return SRC_EXT;
        return 0;
    endfunction

    task automatic check(bit ok, string req, longint act, longint expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic expect_src(int src, longint tmin, longint tmax, string req);
        exp_t e;
        e.src = src; e.tmin = tmin; e.tmax = tmax; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic wait_drain(int limit_ns, string req);
        int waited = 0;
        while (sb_q.size() > 0 && waited < limit_ns) begin
            #10; waited += 10;
        end
        check(sb_q.size() == 0, req, sb_q.size(), 0);
    endtask

    task automatic pulse_stop();
        @(negedge clk_hrc) stop_req = 1;
        @(negedge clk_hrc) stop_req = 0;
    endtask

    task automatic pulse_wake(output longint t);
        @(negedge clk_hrc) wake_irq = 1; t = now_ps();
        @(negedge clk_hrc) wake_irq = 0;
    endtask

    // Monitor: classify every sys_clk edge and score the source changes (R9).
    always @(posedge sys_clk) begin
        longint t;
        int     s;
        t = now_ps();
        s = classify(t);
        edge_cnt++;
        if (s == 0) begin
            check(0, "R9 glitch edge", t, 0);
        end else if (s != cur_src || (t - last_edge) > 60000) begin
            if (sb_q.size() == 0) begin
                check(0, "R9 unexpected source change", s, cur_src);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(s == e.src, e.req, s, e.src);
                check(t >= e.tmin && t <= e.tmax, e.req, t, e.tmin);
            end
        end
        cur_src   = s;
        last_edge = t;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #150000;
        if (!done_flag) begin
            check(0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Driver.
    initial begin
        longint t0, tw;
        int     snap;
        rst_n = 0; osc_en = 0; osc_mode = 2'b00; stop_req = 0; wake_irq = 0;
        // R1: the RC clock appears on sys_clk from the start
        expect_src(SRC_RC, 0, 200000, "R1 RC after reset");
        repeat (40) @(negedge clk_hrc);
        rst_n = 1;
        repeat (20) @(negedge clk_hrc);
        check(sb_q.size() == 0, "R1 RC running", sb_q.size(), 0);
        check(ext_active == 0, "R1 status after reset", ext_active, 0);

        // R3: enable in a non-external mode has no effect
        osc_mode = 2'b01; osc_en = 1;
        #5000;
        check(cur_src == SRC_RC, "R3 stays RC", cur_src, SRC_RC);
        check(ext_active == 0, "R3 status", ext_active, 0);
        @(negedge clk_hrc) osc_en = 0;
        #100;

        // R2: full startup onto the external clock
        @(negedge clk_hrc) osc_mode = 2'b11; osc_en = 1; t0 = now_ps();
        expect_src(SRC_EXT, t0 + 3584000, t0 + 3984000, "R2 ext after 512+128");
        wait_drain(6000, "R2 handover");
        #200;
        check(ext_active == 1, "R10 status on ext", ext_active, 1);

        // R4: clearing the enable returns to RC
        @(negedge clk_hrc) osc_en = 0; t0 = now_ps();
        expect_src(SRC_RC, t0, t0 + 200000, "R4 back to RC");
        wait_drain(1000, "R4 return");
        #200;
        check(ext_active == 0, "R10 status on RC", ext_active, 0);

        // R4: a partial count is discarded
        @(negedge clk_hrc) osc_en = 1;
        #1500;
        @(negedge clk_hrc) osc_en = 0;
        #200;
        @(negedge clk_hrc) osc_en = 1; t0 = now_ps();
        expect_src(SRC_EXT, t0 + 3584000, t0 + 3984000, "R4 full recount");
        wait_drain(6000, "R4 recount handover");
        #200;

        // R5: STOP silences sys_clk
        pulse_stop();
        #300;
        snap = edge_cnt;
        #3000;
        check(edge_cnt == snap, "R5 no edges in STOP", edge_cnt - snap, 0);

        // R6, R7: wake with the enable held, then automatic handover
        pulse_wake(tw);
        expect_src(SRC_RC, tw + 5460000, tw + 6060000, "R6 RC after 29+512");
        expect_src(SRC_EXT, tw + 6484000, tw + 7484000, "R7 auto ext after wake");
        wait_drain(9000, "R7 wake sequence");
        #200;
        check(ext_active == 1, "R7 status after wake", ext_active, 1);

        // R8: wake with the enable cleared stays on RC
        @(negedge clk_hrc) osc_en = 0; t0 = now_ps();
        expect_src(SRC_RC, t0, t0 + 200000, "R4 back to RC before stop");
        wait_drain(1000, "R4 return 2");
        pulse_stop();
        #300;
        snap = edge_cnt;
        #2000;
        check(edge_cnt == snap, "R5 no edges in second STOP", edge_cnt - snap, 0);
        pulse_wake(tw);
        expect_src(SRC_RC, tw + 5460000, tw + 6060000, "R6 RC after second wake");
        wait_drain(8000, "R6 second wake");
        #3000;
        check(cur_src == SRC_RC, "R8 stays RC", cur_src, SRC_RC);
        check(ext_active == 0, "R8 status", ext_active, 0);
        check(sb_q.size() == 0, "R9 scoreboard empty", sb_q.size(), 0);

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule